// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 128-bit packed-integer execution unit. Each cycle it can accept one operation on two 128-bit operands. A per-operation control selects the element size: sixteen bytes, eight halfwords or four words. A second control chooses signed or unsigned interpretation. The unit performs one of four operations: wrapping addition, clamping addition, element-wise equality compare, or bitwise select under a third 128-bit mask operand.

Compare results are written as whole-element masks of all ones or all zeros. The intended use is to feed such a mask back as the third operand of a select. Every operation completes with exactly one register stage, so results come back one cycle after issue, with a valid flag. A single flag reports whether any lane of a clamping addition was clamped.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `sat_any` are all zero.
- R2: An operation presented with `in_valid` high at a rising edge appears on `result` with `out_valid` high after exactly that one edge. Operations may be issued on every cycle. `out_valid` is low in a cycle that follows an edge where `in_valid` was low.
- R3: `op` encodes 2'b00 wrapping add, 2'b01 clamping add, 2'b10 compare-equal, 2'b11 select. `esize` encodes 2'b00 bytes, 2'b01 halfwords, 2'b10 or 2'b11 words. Element k occupies bits [k*w +: w].
- R4: Wrapping add produces each element sum modulo 2^w. No carry crosses an element boundary, and `sat_any` is 0.
- R5: A signed clamping add (`is_signed`=1) yields 2^(w-1)-1 for a lane on positive overflow and -2^(w-1) on negative overflow. Otherwise it yields the exact sum.
- R6: An unsigned clamping add (`is_signed`=0) yields all ones for a lane whose sum exceeds 2^w-1. Otherwise it yields the exact sum.
- R7: `sat_any` is 1 exactly when the result is a clamping add in which at least one lane was clamped. It is 0 for all other operations.
- R8: Compare-equal sets each element to all ones when the two operand elements are equal and to all zeros otherwise, independent of `is_signed`.
- R9: Select takes each result bit from `opb` where the matching `opc` bit is 1 and from `opa` where it is 0, independent of `esize` and `is_signed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | Operation code |
| esize | input | 2 | Element size select |
| is_signed | input | 1 | Signed element interpretation |
| opa | input | 128 | First operand |
| opb | input | 128 | Second operand |
| opc | input | 128 | Select mask operand |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Packed result |
| sat_any | output | 1 | Any lane clamped in this result |

## Verification
The assertions assume that `in_valid` and the operand and control inputs are stable around the rising edge. They also assume that `in_valid` is held low while reset is being released, so that the first valid result can only follow a real issue. The stimulus drives every input on the falling edge and keeps `in_valid` low for the whole reset period. All four `esize` codes, both signedness values and every opcode are applied, both as directed boundary vectors and as random back-to-back traffic. The expected values come from an element-level arithmetic model.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [1:0]   esize,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         sat_any
);
  localparam int NB = W / 8;

  logic [7:0]    sum_b [NB];
  logic [NB-1:0] cout_b;
  logic [NB-1:0] eq_b;
  logic [W-1:0]  add_wrap, add_clamp, cmp_mask, sel_bits, nxt;
  logic          clamp_hit;
  int            emask;

  always_comb begin
    case (esize)
      2'b00:   emask = 0;
      2'b01:   emask = 1;
      default: emask = 3;
    endcase
  end

  always_comb begin
    logic c;
    logic [8:0] s;
    c = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if ((i & emask) == 0) c = 1'b0;
      s = {1'b0, opa[i*8 +: 8]} + {1'b0, opb[i*8 +: 8]} + {8'd0, c};
      sum_b[i]  = s[7:0];
      cout_b[i] = s[8];
      c         = s[8];
      eq_b[i]   = (opa[i*8 +: 8] == opb[i*8 +: 8]);
    end
  end

  always_comb begin
    int  t, base;
    logic am, bm, sm, pos, neg, ovf, e_eq;
    add_wrap  = '0;
    add_clamp = '0;
    cmp_mask  = '0;
    clamp_hit = 1'b0;
    for (int i = 0; i < NB; i++) begin
      t    = i | emask;
      base = i & ~emask;
      am   = opa[t*8 + 7];
      bm   = opb[t*8 + 7];
      sm   = sum_b[t][7];
      pos  = is_signed & ~am & ~bm & sm;
      neg  = is_signed & am & bm & ~sm;
      ovf  = ~is_signed & cout_b[t];
      add_wrap[i*8 +: 8] = sum_b[i];
      if (pos)
        add_clamp[i*8 +: 8] = (i == t) ? 8'h7F : 8'hFF;
      else if (neg)
        add_clamp[i*8 +: 8] = (i == t) ? 8'h80 : 8'h00;
      else if (ovf)
        add_clamp[i*8 +: 8] = 8'hFF;
      else
        add_clamp[i*8 +: 8] = sum_b[i];
      clamp_hit = clamp_hit | pos | neg | ovf;
      e_eq = 1'b1;
      for (int j = 0; j < 4; j++)
        if (j <= emask) e_eq = e_eq & eq_b[base + j];
      cmp_mask[i*8 +: 8] = {8{e_eq}};
    end
  end

  assign sel_bits = (opa & ~opc) | (opb & opc);

  always_comb begin
    case (op)
      2'b00:   nxt = add_wrap;
      2'b01:   nxt = add_clamp;
      2'b10:   nxt = cmp_mask;
      default: nxt = sel_bits;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_any   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt;
        sat_any <= (op == 2'b01) & clamp_hit;
      end
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic [1:0]   esize,
  input logic         is_signed,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] opc,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         sat_any
);
  function automatic logic all_mask_bytes(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W/8; i++)
      ok = ok & ((v[i*8 +: 8] == 8'h00) | (v[i*8 +: 8] == 8'hFF));
    return ok;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !sat_any && result == '0));

  p_issue_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_wrap_nosat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00) |=> !sat_any);

  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'b01) |=> !sat_any);

  p_cmp_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10) |=> all_mask_bytes(result));

  p_select_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=>
      result == (($past(opa) & ~$past(opc)) | ($past(opb) & $past(opc))));
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.W(W)) u_chk (.*);

// File: tb/simd_sat_alu_tb.sv
`timescale 1ns/1ps
module simd_sat_alu_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op = '0;
  logic [1:0]   esize = '0;
  logic         is_signed = 1'b0;
  logic [127:0] opa = '0, opb = '0, opc = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_any;

  typedef struct {
    logic [127:0] res;
    logic         sat;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  simd_sat_alu u_dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [128:0] model(logic [1:0] o, logic [1:0] sz, logic sg,
                                         logic [127:0] a, logic [127:0] b, logic [127:0] c);
    int eb, w, n;
    longint unsigned msk, au, bu, r;
    longint sa, sb, s, mx, mn;
    logic [127:0] res;
    logic sat;
    eb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    w = eb * 8;
    n = 16 / eb;
    msk = (64'd1 << w) - 1;
    res = '0;
    sat = 1'b0;
    if (o == 2'b11) return {1'b0, (a & ~c) | (b & c)};
    for (int k = 0; k < n; k++) begin
      au = 64'(a >> (k*w)) & msk;
      bu = 64'(b >> (k*w)) & msk;
      sa = longint'(au);
      sb = longint'(bu);
      if (sg) begin
        if (au[w-1]) sa = sa - (longint'(1) << w);
        if (bu[w-1]) sb = sb - (longint'(1) << w);
        mx = (longint'(1) << (w-1)) - 1;
        mn = -(longint'(1) << (w-1));
      end else begin
        mx = longint'(msk);
        mn = 0;
      end
      case (o)
        2'b00: r = (au + bu) & msk;
        2'b01: begin
          s = sa + sb;
          if (s > mx) begin s = mx; sat = 1'b1; end
          else if (s < mn) begin s = mn; sat = 1'b1; end
          r = longint'(s) & msk;
        end
        default: r = (au == bu) ? msk : 64'd0;
      endcase
      res = res | (128'(r) << (k*w));
    end
    return {sat, res};
  endfunction

  task automatic issue(input logic [1:0] o, input logic [1:0] sz, input logic sg,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                       input string tag);
    exp_t e;
    logic [128:0] m;
    @(negedge clk);
    in_valid = 1'b1; op = o; esize = sz; is_signed = sg;
    opa = a; opb = b; opc = c;
    m = model(o, sz, sg, a, b, c);
    e.res = m[127:0];
    e.sat = m[128];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = '1; opb = '1; op = 2'b01;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2: out_valid=1 got %h, expected no result", result);
        end else begin
          e = exp_q.pop_front();
          if (result !== e.res || sat_any !== e.sat) begin
            n_bad++;
            $display("FAIL %s: got %h sat=%b, expected %h sat=%b",
                     e.tag, result, sat_any, e.res, e.sat);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== '0 || sat_any !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got v=%b r=%h s=%b, expected 0/0/0", out_valid, result, sat_any);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: got out_valid=%b after idle, expected 0", out_valid);
    end

    issue(2'b00, 2'b00, 1'b0, {16{8'hFF}}, {16{8'h01}}, '0, "R4 byte wrap");
    issue(2'b00, 2'b01, 1'b0, {8{16'h00FF}}, {8{16'h0001}}, '0, "R3 R4 halfword carry");
    issue(2'b00, 2'b10, 1'b0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, '0, "R3 R4 word lane isolation");
    issue(2'b01, 2'b01, 1'b1, {8{16'h7FFF}}, {8{16'h0001}}, '0, "R5 R7 signed half pos clamp");
    issue(2'b01, 2'b01, 1'b1, {8{16'h8000}}, {8{16'hFFFF}}, '0, "R5 R7 signed half neg clamp");
    issue(2'b01, 2'b00, 1'b1, {8{8'h70, 8'h90}}, {8{8'h20, 8'hE0}}, '0, "R5 signed byte mixed");
    issue(2'b01, 2'b10, 1'b0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, '0, "R6 R7 unsigned word clamp");
    issue(2'b01, 2'b11, 1'b1, {4{32'h7FFF_FFFF}}, {4{32'h0000_0001}}, '0, "R3 R5 esize 11 as word");
    issue(2'b01, 2'b00, 1'b0, {16{8'h10}}, {16{8'h20}}, '0, "R7 no clamp flag low");
    issue(2'b01, 2'b00, 1'b0, {8'hFF, {15{8'h01}}}, {8'h02, {15{8'h01}}}, '0, "R6 R7 single lane clamp");
    issue(2'b10, 2'b00, 1'b0,
          128'hC1000000_1A1AC11A_00C10000_1A001AC1, '0, '0, "R8 byte compare");
    issue(2'b10, 2'b01, 1'b1, {8{16'h1234}}, {4{16'h1234, 16'h1235}}, '0, "R8 halfword compare");
    issue(2'b10, 2'b10, 1'b0, {4{32'hAABB_CCDD}}, {32'hAABB_CCDD, 32'h0, 32'hAABB_CCDD, 32'hAABB_CCDC},
          '0, "R8 word compare");
    issue(2'b11, 2'b00, 1'b0, 128'hC1000000_1A1AC11A_00C10000_1A001AC1, {16{8'h9A}},
          128'hFF000000_FFFFFFFF_00FF0000_FF00FFFF, "R9 select");
    issue(2'b11, 2'b10, 1'b1, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, {32{4'hA}}, "R9 select bitwise");
    idle(3);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: got out_valid=%b while idle, expected 0", out_valid);
    end

    for (int i = 0; i < 400; i++) begin
      logic [1:0] o, z;
      logic g;
      o = 2'($urandom_range(0, 3));
      z = 2'($urandom_range(0, 3));
      g = 1'($urandom_range(0, 1));
      issue(o, z, g, {$urandom, $urandom, $urandom, $urandom},
            (i % 5 == 0) ? {$urandom, $urandom, $urandom, $urandom} & 128'hFFFF_0000_FF00_00FF_FFFF_0000_FF00_00FF
                         : {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, "R2 R3 random back-to-back");
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule